// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Per-Port Burst Address Counters

This block is a true two-port synchronous memory of 9-bit words. Each side (left and right) has its own clock, synchronous reset, address, write data and read data, and both sides may reach the same word in the same cycle. Address, write data and control are captured on the rising edge of the side's own clock. The captured address comes from a per-side address register. Three active-low controls act on that register: one clears it, one loads it from the address pins, and one advances it by one for sequential bursts.

An access on a side takes place only when its low-true select is low and its high-true select is high. A read is returned either in flow-through form, in the cycle that follows the capturing edge, or in pipelined form, one clock later through an extra register. A mode pin on each side picks between the two. The bidirectional data pads are modelled as a data-out bus plus a drive-enable flag. An asynchronous active-low output enable removes the drive at once. The storage depth is 2^ADDR_W words (package constant, 10 by default; 14 gives 16K words). A parameter builds a half-depth variant that ignores the top address bit.

Top module: `dual_burst_ram`

## Requirements
- R1: A word written through either side can be read back through either side, and reads on both sides may target the same word in the same cycle.
- R2: A side is selected only when `sel_lo_n`=0 and `sel_hi`=1 at the clock edge. Any other combination performs no write and leaves `dout_en`=0 for that access.
- R3: With the side selected, `wr_n`=0 at the edge writes `din` to the captured address, and `wr_n`=1 reads that address.
- R4: `oe_n` acts without a clock. While it is 1, `dout_en`=0 and `dout`=0. Whenever `dout_en`=0 the `dout` bus reads 0.
- R5: With `flow`=1, read data and `dout_en`=1 appear in the cycle right after the capturing edge. With `flow`=0 they appear one cycle later.
- R6: `clr_n`=0 sets the address register to 0, and it takes priority over `ld_n` and `inc_n`.
- R7: With `clr_n`=1 and `ld_n`=0, the address register takes the value on `addr`.
- R8: With `clr_n`=1, `ld_n`=1 and `inc_n`=0, the address register increments by one and wraps from the top address to 0.
- R9: With all three counter controls at 1, the address register holds its value.
- R10: If one side writes a word and the other side reads it in the same cycle, the read returns the previous contents. A read of that word in the next cycle returns the new data.
- R11: If both sides write the same word in the same cycle, the left side's data is kept.
- R12: With `HALF_DEPTH`=1, the top address bit is ignored, so addresses differing only in that bit reach the same word and the counter wraps from half depth to 0.
- R13: A side's synchronous active-high reset clears its address register to 0 and withdraws its output drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left-side clock |
| rst_l | input | 1 | Left-side synchronous reset, active high |
| sel_lo_n_l | input | 1 | Left select, active low |
| sel_hi_l | input | 1 | Left select, active high |
| wr_n_l | input | 1 | Left write when 0, read when 1 |
| addr_l | input | ADDR_W | Left external address |
| din_l | input | DATA_W | Left write data |
| ld_n_l | input | 1 | Left address load strobe, active low |
| inc_n_l | input | 1 | Left counter advance, active low |
| clr_n_l | input | 1 | Left counter clear, active low |
| flow_l | input | 1 | Left read mode: 1 flow-through, 0 pipelined |
| oe_n_l | input | 1 | Left asynchronous output enable, active low |
| dout_l | output | DATA_W | Left read data, 0 when not driven |
| dout_en_l | output | 1 | Left data drive enable |
| clk_r | input | 1 | Right-side clock |
| rst_r | input | 1 | Right-side synchronous reset, active high |
| sel_lo_n_r | input | 1 | Right select, active low |
| sel_hi_r | input | 1 | Right select, active high |
| wr_n_r | input | 1 | Right write when 0, read when 1 |
| addr_r | input | ADDR_W | Right external address |
| din_r | input | DATA_W | Right write data |
| ld_n_r | input | 1 | Right address load strobe, active low |
| inc_n_r | input | 1 | Right counter advance, active low |
| clr_n_r | input | 1 | Right counter clear, active low |
| flow_r | input | 1 | Right read mode: 1 flow-through, 0 pipelined |
| oe_n_r | input | 1 | Right asynchronous output enable, active low |
| dout_r | output | DATA_W | Right read data, 0 when not driven |
| dout_en_r | output | 1 | Right data drive enable |

## Verification
The bench targets the same-word cases between the two sides. A read that sees a write landing in the same cycle would show the new word one cycle too early. A same-word double write that lets the right side win would leave the right side's data behind. Burst reads are run across the top-address wrap and with a clear raised together with a load. A counter that lets the load override the clear, or that runs past the last word, returns the wrong word. The pipelined mode is checked for exactly one extra cycle of latency. The output enable is toggled between clock edges to catch a registered rather than immediate disable. A half-depth instance is checked for aliasing of the top address bit and for wrapping at half depth.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    parameter int DATA_W = 9;
    parameter int ADDR_W = 10;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // address register operation, in priority order
    typedef enum logic [1:0] {
        AOP_HOLD  = 2'd0,
        AOP_CLEAR = 2'd1,
        AOP_LOAD  = 2'd2,
        AOP_STEP  = 2'd3
    } aop_e;

    // one captured access of a side
    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        word_t data;
    } acc_t;

    function automatic aop_e decode_aop(input logic clr_n, input logic ld_n, input logic inc_n);
        aop_e op;
        if (!clr_n)      op = AOP_CLEAR;
        else if (!ld_n)  op = AOP_LOAD;
        else if (!inc_n) op = AOP_STEP;
        else             op = AOP_HOLD;
        return op;
    endfunction

    // half-depth build drops the top address bit
    function automatic addr_t fold_addr(input addr_t a, input logic half);
        addr_t r;
        r = a;
        if (half) r[ADDR_W-1] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/dpr_addr_unit.sv
module dpr_addr_unit
    import dpr_pkg::*;
#(
    parameter bit HALF = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_lo_n,
    input  logic  sel_hi,
    input  logic  wr_n,
    input  addr_t addr_in,
    input  word_t din,
    input  logic  ld_n,
    input  logic  inc_n,
    input  logic  clr_n,
    output acc_t  acc_q
);

    aop_e  op;
    addr_t nxt_addr;
    logic  sel;

    assign sel = !sel_lo_n && sel_hi;

    always_comb begin
        op = decode_aop(clr_n, ld_n, inc_n);
        unique case (op)
            AOP_CLEAR: nxt_addr = '0;
            AOP_LOAD:  nxt_addr = fold_addr(addr_in, HALF);
            AOP_STEP:  nxt_addr = fold_addr(acc_q.addr + addr_t'(1), HALF);
            default:   nxt_addr = acc_q.addr;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else begin
            acc_q.wr   <= sel && !wr_n;
            acc_q.rd   <= sel && wr_n;
            acc_q.addr <= nxt_addr;
            acc_q.data <= din;
        end
    end

    a_r6_clear_first: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> acc_q.addr == '0);

    a_r7_load_addr: assert property (@(posedge clk) disable iff (rst)
        (clr_n && !ld_n) |=> acc_q.addr == fold_addr($past(addr_in), HALF));

    a_r8_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && !inc_n) |=> acc_q.addr == fold_addr($past(acc_q.addr) + addr_t'(1), HALF));

    a_r9_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (clr_n && ld_n && inc_n) |=> $stable(acc_q.addr));

    a_r2_no_access: assert property (@(posedge clk) disable iff (rst)
        !(!sel_lo_n && sel_hi) |=> (!acc_q.wr && !acc_q.rd));

endmodule

// File: rtl/dpr_read_path.sv
module dpr_read_path
    import dpr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flow_thru,
    input  logic  oe_n,
    input  logic  rd_q,
    input  word_t arr_q,
    output word_t dout,
    output logic  dout_en
);

    logic  pv_q;
    word_t pd_q;
    logic  live_v;
    word_t live_d;

    always_ff @(posedge clk) begin
        if (rst) pv_q <= 1'b0;
        else     pv_q <= rd_q;
        pd_q <= arr_q;
    end

    assign live_v  = flow_thru ? rd_q  : pv_q;
    assign live_d  = flow_thru ? arr_q : pd_q;
    assign dout_en = live_v && !oe_n;
    assign dout    = dout_en ? live_d : '0;

    // R5: a pipelined read drives one cycle after it is captured
    a_r5_pipe_lag: assert property (@(posedge clk) disable iff (rst)
        (!flow_thru && rd_q) |=> (flow_thru || oe_n || dout_en));

endmodule

// File: rtl/dpr_xor_store.sv
module dpr_xor_store
    import dpr_pkg::*;
(
    input  logic  clk_a,
    input  logic  we_a,
    input  addr_t wa_a,
    input  word_t wd_a,
    input  logic  clk_b,
    input  logic  we_b,
    input  addr_t wa_b,
    input  word_t wd_b,
    input  addr_t ra_a,
    input  addr_t ra_b,
    output word_t rd_a,
    output word_t rd_b
);

    localparam int DEPTH = 1 << ADDR_W;

    // each bank has one writer; a word is the XOR of both banks
    word_t bank_a [DEPTH];
    word_t bank_b [DEPTH];

    always_ff @(posedge clk_a) begin
        if (we_a) bank_a[wa_a] <= wd_a ^ bank_b[wa_a];
    end

    always_ff @(posedge clk_b) begin
        if (we_b) bank_b[wa_b] <= wd_b ^ bank_a[wa_b];
    end

    assign rd_a = bank_a[ra_a] ^ bank_b[ra_a];
    assign rd_b = bank_a[ra_b] ^ bank_b[ra_b];

endmodule

// File: rtl/dual_burst_ram.sv
module dual_burst_ram
    import dpr_pkg::*;
#(
    parameter bit HALF_DEPTH = 1'b0
) (
    input  logic              clk_l,
    input  logic              rst_l,
    input  logic              sel_lo_n_l,
    input  logic              sel_hi_l,
    input  logic              wr_n_l,
    input  logic [ADDR_W-1:0] addr_l,
    input  logic [DATA_W-1:0] din_l,
    input  logic              ld_n_l,
    input  logic              inc_n_l,
    input  logic              clr_n_l,
    input  logic              flow_l,
    input  logic              oe_n_l,
    output logic [DATA_W-1:0] dout_l,
    output logic              dout_en_l,
    input  logic              clk_r,
    input  logic              rst_r,
    input  logic              sel_lo_n_r,
    input  logic              sel_hi_r,
    input  logic              wr_n_r,
    input  logic [ADDR_W-1:0] addr_r,
    input  logic [DATA_W-1:0] din_r,
    input  logic              ld_n_r,
    input  logic              inc_n_r,
    input  logic              clr_n_r,
    input  logic              flow_r,
    input  logic              oe_n_r,
    output logic [DATA_W-1:0] dout_r,
    output logic              dout_en_r
);

    localparam int NPORT = 2;

    logic  [NPORT-1:0] clk_v, rst_v, sel_lo_v, sel_hi_v, wr_n_v;
    logic  [NPORT-1:0] ld_v, inc_v, clr_v, flow_v, oe_v, en_v;
    addr_t [NPORT-1:0] addr_v;
    word_t [NPORT-1:0] din_v, dout_v, rdata_v;
    word_t             rd_l_w, rd_r_w;
    logic              we_l_s, we_r_s;

    assign clk_v    = {clk_r, clk_l};
    assign rst_v    = {rst_r, rst_l};
    assign sel_lo_v = {sel_lo_n_r, sel_lo_n_l};
    assign sel_hi_v = {sel_hi_r, sel_hi_l};
    assign wr_n_v   = {wr_n_r, wr_n_l};
    assign ld_v     = {ld_n_r, ld_n_l};
    assign inc_v    = {inc_n_r, inc_n_l};
    assign clr_v    = {clr_n_r, clr_n_l};
    assign flow_v   = {flow_r, flow_l};
    assign oe_v     = {oe_n_r, oe_n_l};
    assign addr_v   = {addr_r, addr_l};
    assign din_v    = {din_r, din_l};
    assign rdata_v  = {rd_r_w, rd_l_w};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        acc_t acc_q;

        dpr_addr_unit #(.HALF(HALF_DEPTH)) u_addr (
            .clk      (clk_v[p]),
            .rst      (rst_v[p]),
            .sel_lo_n (sel_lo_v[p]),
            .sel_hi   (sel_hi_v[p]),
            .wr_n     (wr_n_v[p]),
            .addr_in  (addr_v[p]),
            .din      (din_v[p]),
            .ld_n     (ld_v[p]),
            .inc_n    (inc_v[p]),
            .clr_n    (clr_v[p]),
            .acc_q    (acc_q)
        );

        dpr_read_path u_rd (
            .clk       (clk_v[p]),
            .rst       (rst_v[p]),
            .flow_thru (flow_v[p]),
            .oe_n      (oe_v[p]),
            .rd_q      (acc_q.rd),
            .arr_q     (rdata_v[p]),
            .dout      (dout_v[p]),
            .dout_en   (en_v[p])
        );
    end

    // captured writes land one edge later; left wins a same-word clash
    assign we_l_s = g_port[0].acc_q.wr;
    assign we_r_s = g_port[1].acc_q.wr &&
                    !(g_port[0].acc_q.wr && (g_port[0].acc_q.addr == g_port[1].acc_q.addr));

    dpr_xor_store u_store (
        .clk_a (clk_l),
        .we_a  (we_l_s),
        .wa_a  (g_port[0].acc_q.addr),
        .wd_a  (g_port[0].acc_q.data),
        .clk_b (clk_r),
        .we_b  (we_r_s),
        .wa_b  (g_port[1].acc_q.addr),
        .wd_b  (g_port[1].acc_q.data),
        .ra_a  (g_port[0].acc_q.addr),
        .ra_b  (g_port[1].acc_q.addr),
        .rd_a  (rd_l_w),
        .rd_b  (rd_r_w)
    );

    assign dout_l    = dout_v[0];
    assign dout_en_l = en_v[0];
    assign dout_r    = dout_v[1];
    assign dout_en_r = en_v[1];

    // R11: the store never sees two writers on one word
    a_r11_one_writer: assert property (@(posedge clk_l) disable iff (rst_l)
        !(we_l_s && we_r_s && (g_port[0].acc_q.addr == g_port[1].acc_q.addr)));

endmodule

// File: tb/dual_burst_ram_tb.sv
module dual_burst_ram_tb;
    import dpr_pkg::*;

    typedef struct {
        int          port;
        logic        en;
        logic [8:0]  d;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        sel_lo_n [2], sel_hi [2], wr_n [2], ld_n [2], inc_n [2], clr_n [2], ft [2], oe_n [2];
    addr_t       addr [2];
    word_t       din [2];
    word_t       dout [2];
    logic        dout_en [2];

    logic        h_sel_lo_n, h_sel_hi, h_wr_n, h_ld_n, h_inc_n;
    addr_t       h_addr;
    word_t       h_din, h_dout, h_dout_r;
    logic        h_en, h_en_r;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    exp_t  q [$];
    word_t ref_mem [1 << ADDR_W];
    logic  m_wr [2], m_rd [2], m_pv [2];
    addr_t m_addr [2];
    word_t m_din [2], m_pd [2];

    dual_burst_ram u_dut (
        .clk_l(clk), .rst_l(rst), .sel_lo_n_l(sel_lo_n[0]), .sel_hi_l(sel_hi[0]), .wr_n_l(wr_n[0]),
        .addr_l(addr[0]), .din_l(din[0]), .ld_n_l(ld_n[0]), .inc_n_l(inc_n[0]), .clr_n_l(clr_n[0]),
        .flow_l(ft[0]), .oe_n_l(oe_n[0]), .dout_l(dout[0]), .dout_en_l(dout_en[0]),
        .clk_r(clk), .rst_r(rst), .sel_lo_n_r(sel_lo_n[1]), .sel_hi_r(sel_hi[1]), .wr_n_r(wr_n[1]),
        .addr_r(addr[1]), .din_r(din[1]), .ld_n_r(ld_n[1]), .inc_n_r(inc_n[1]), .clr_n_r(clr_n[1]),
        .flow_r(ft[1]), .oe_n_r(oe_n[1]), .dout_r(dout[1]), .dout_en_r(dout_en[1])
    );

    dual_burst_ram #(.HALF_DEPTH(1'b1)) u_dut_half (
        .clk_l(clk), .rst_l(rst), .sel_lo_n_l(h_sel_lo_n), .sel_hi_l(h_sel_hi), .wr_n_l(h_wr_n),
        .addr_l(h_addr), .din_l(h_din), .ld_n_l(h_ld_n), .inc_n_l(h_inc_n), .clr_n_l(1'b1),
        .flow_l(1'b1), .oe_n_l(1'b0), .dout_l(h_dout), .dout_en_l(h_en),
        .clk_r(clk), .rst_r(rst), .sel_lo_n_r(1'b1), .sel_hi_r(1'b0), .wr_n_r(1'b1),
        .addr_r('0), .din_r('0), .ld_n_r(1'b1), .inc_n_r(1'b1), .clr_n_r(1'b1),
        .flow_r(1'b1), .oe_n_r(1'b0), .dout_r(h_dout_r), .dout_en_r(h_en_r)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input int p, input bit sel, input bit wr, input bit ld, input int a, input int d);
        sel_lo_n[p] = !sel;
        sel_hi[p]   = sel;
        wr_n[p]     = !wr;
        ld_n[p]     = !ld;
        inc_n[p]    = 1'b1;
        clr_n[p]    = 1'b1;
        addr[p]     = addr_t'(a);
        din[p]      = word_t'(d);
    endtask

    task automatic idle(input int p);
        drive(p, 1'b0, 1'b0, 1'b0, 0, 0);
    endtask

    // driver: advance one edge, update the reference, push expected outputs
    task automatic tick(input string req);
        exp_t e;
        @(posedge clk);
        for (int p = 0; p < 2; p++) m_pd[p] = ref_mem[m_addr[p]];
        if (m_wr[0]) ref_mem[m_addr[0]] = m_din[0];
        if (m_wr[1] && !(m_wr[0] && m_addr[0] == m_addr[1])) ref_mem[m_addr[1]] = m_din[1];
        for (int p = 0; p < 2; p++) begin
            if (rst) begin
                m_pv[p] = 1'b0; m_wr[p] = 1'b0; m_rd[p] = 1'b0; m_addr[p] = '0; m_din[p] = '0;
            end else begin
                m_pv[p]  = m_rd[p];
                m_wr[p]  = !sel_lo_n[p] && sel_hi[p] && !wr_n[p];
                m_rd[p]  = !sel_lo_n[p] && sel_hi[p] && wr_n[p];
                m_din[p] = din[p];
                if (!clr_n[p])      m_addr[p] = '0;
                else if (!ld_n[p])  m_addr[p] = addr[p];
                else if (!inc_n[p]) m_addr[p] = m_addr[p] + addr_t'(1);
            end
            e.port = p;
            e.req  = req;
            e.en   = (ft[p] ? m_rd[p] : m_pv[p]) && !oe_n[p];
            e.d    = e.en ? (ft[p] ? ref_mem[m_addr[p]] : m_pd[p]) : '0;
            q.push_back(e);
        end
        @(negedge clk);
        #1;
    endtask

    // monitor: pop and compare away from the active edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                e = q.pop_front();
                check(e.req, $sformatf("port%0d {en,data}", e.port),
                      {22'd0, dout_en[e.port], dout[e.port]}, {22'd0, e.en, e.d});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) ref_mem[i] = '0;
        for (int p = 0; p < 2; p++) begin
            idle(p); ft[p] = 1'b1; oe_n[p] = 1'b0;
            m_wr[p] = 0; m_rd[p] = 0; m_pv[p] = 0; m_addr[p] = '0; m_din[p] = '0; m_pd[p] = '0;
        end
        h_sel_lo_n = 1'b1; h_sel_hi = 1'b0; h_wr_n = 1'b1; h_ld_n = 1'b1; h_inc_n = 1'b1;
        h_addr = '0; h_din = '0;

        // R13: outputs quiet during reset
        repeat (3) tick("R13");
        rst = 1'b0;

        // R3: plain writes and reads
        drive(0, 1, 1, 1, 0, 'h155); tick("R3");
        drive(0, 1, 1, 1, 5, 'h1A5); tick("R3");
        drive(0, 1, 0, 1, 5, 0); drive(1, 1, 0, 1, 5, 0); tick("R1");
        idle(0); idle(1); tick("R1");

        // R2: deselect combinations neither write nor drive
        drive(0, 1, 1, 1, 5, 'h0FF); sel_lo_n[0] = 1'b1; tick("R2");
        drive(0, 1, 1, 1, 5, 'h0FF); sel_hi[0] = 1'b0; tick("R2");
        drive(0, 1, 0, 1, 5, 0); tick("R2");
        idle(0); tick("R2");

        // R5: pipelined latency, single and back to back
        ft[0] = 1'b0;
        drive(0, 1, 0, 1, 5, 0); tick("R5");
        idle(0); tick("R5"); tick("R5");
        drive(0, 1, 0, 1, 0, 0); tick("R5");
        drive(0, 1, 0, 1, 5, 0); tick("R5");
        idle(0); tick("R5"); tick("R5");
        ft[0] = 1'b1;

        // R7 and R8: burst write across the top, then burst read
        drive(1, 1, 1, 1, (1 << ADDR_W) - 4, 'h011); tick("R7");
        drive(1, 1, 1, 0, 0, 'h022); inc_n[1] = 1'b0; tick("R8");
        din[1] = 'h033; tick("R8");
        din[1] = 'h044; tick("R8");
        din[1] = 'h0E5; tick("R8");
        drive(1, 1, 0, 1, (1 << ADDR_W) - 4, 0); tick("R7");
        drive(1, 1, 0, 0, 0, 0); inc_n[1] = 1'b0;
        repeat (4) tick("R8");
        drive(1, 1, 0, 0, 0, 0); repeat (2) tick("R9");

        // R6: clear beats a simultaneous load
        drive(1, 1, 0, 1, 7, 0); clr_n[1] = 1'b0; tick("R6");
        idle(1); tick("R6");

        // R10: write on left, same-word read on right
        drive(0, 1, 1, 1, 9, 'h0C3); tick("R10");
        drive(0, 1, 1, 1, 9, 'h13C); drive(1, 1, 0, 1, 9, 0); tick("R10");
        idle(0); drive(1, 1, 0, 0, 0, 0); tick("R10");
        idle(1); tick("R10");

        // R11: same-word double write keeps the left data
        drive(0, 1, 1, 1, 12, 'h0AA); drive(1, 1, 1, 1, 12, 'h155); tick("R11");
        idle(0); idle(1); tick("R11");
        drive(1, 1, 0, 1, 12, 0); tick("R11");
        idle(1); tick("R11");

        // R4: output enable acts between edges
        drive(0, 1, 0, 1, 12, 0); tick("R4");
        oe_n[0] = 1'b1; #1;
        check("R4", "dout_en with oe_n high", {31'd0, dout_en[0]}, 32'd0);
        check("R4", "dout with oe_n high", {23'd0, dout[0]}, 32'd0);
        oe_n[0] = 1'b0; #1;
        check("R4", "dout with oe_n low again", {22'd0, dout_en[0], dout[0]}, {22'd0, 1'b1, 9'h0AA});
        idle(0); tick("R4");

        // R13: reset returns the address register to 0
        drive(0, 1, 0, 1, 40, 0); tick("R13");
        rst = 1'b1; tick("R13");
        rst = 1'b0;
        drive(0, 1, 0, 0, 99, 0); tick("R13");
        idle(0); tick("R13");

        // R12: half-depth aliasing and wrap at half
        h_sel_lo_n = 1'b0; h_sel_hi = 1'b1; h_wr_n = 1'b0; h_ld_n = 1'b0;
        h_addr = addr_t'((1 << (ADDR_W - 1)) + 3); h_din = 'h077; tick("R12");
        h_wr_n = 1'b1; h_addr = addr_t'(3); tick("R12");
        check("R12", "half alias read", {22'd0, h_en, h_dout}, {22'd0, 1'b1, 9'h077});
        h_wr_n = 1'b0; h_addr = '0; h_din = 'h055; tick("R12");
        h_addr = addr_t'((1 << (ADDR_W - 1)) - 1); h_din = 'h0AA; tick("R12");
        h_wr_n = 1'b1; h_ld_n = 1'b1; h_inc_n = 1'b0; tick("R12");
        check("R12", "half wrap read", {22'd0, h_en, h_dout}, {22'd0, 1'b1, 9'h055});
        h_sel_lo_n = 1'b1; h_sel_hi = 1'b0; h_inc_n = 1'b1;

        // R1: random traffic on a small window to force clashes
        for (int p = 0; p < 2; p++) begin
            drive(p, 1, 1, 1, p * 8, 'h100 + p); tick("R1");
            for (int k = 1; k < 8; k++) begin
                drive(p, 1, 1, 0, 0, 'h100 + p * 8 + k); inc_n[p] = 1'b0; tick("R1");
            end
            idle(p);
        end
        for (int n = 0; n < 3000; n++) begin
            for (int p = 0; p < 2; p++) begin
                int r;
                r = $urandom % 8;
                drive(p, ($urandom % 6) != 0, ($urandom % 2) == 1, 1, $urandom % 16, $urandom % 512);
                if (r == 0) begin
                    ld_n[p] = 1'b1; clr_n[p] = 1'b0;
                end else if (r == 1 && m_addr[p] < 15) begin
                    ld_n[p] = 1'b1; inc_n[p] = 1'b0;
                end
                if (($urandom % 7) == 0) begin
                    sel_lo_n[p] = $urandom % 2; sel_hi[p] = $urandom % 2;
                end
                ft[p]   = $urandom % 2;
                oe_n[p] = ($urandom % 9) == 0;
            end
            tick("R1");
        end
        idle(0); idle(1); tick("R1"); tick("R1");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule